// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Programming Sequencer

This block holds the two threshold registers that place the almost-empty and almost-full flags of a dual-clock FIFO at a chosen distance from the empty and full boundaries. It sits beside the FIFO storage and reuses the FIFO's own write and read ports for programming. An active-low load select turns a write into a threshold write and a read into a threshold readback. When the load select is high, the block passes the enables through as ordinary FIFO write and read strobes.

In the write clock domain, a round-robin selector chooses which threshold register the next load write fills. It starts with the almost-empty threshold, moves to the almost-full threshold and then wraps. The selector keeps its position when load goes high, so programming can stop after one register and resume later. The read clock domain has its own selector with the same almost-empty-then-almost-full order. That selector places the thresholds, zero-extended, on a registered readback bus. Reset restores both thresholds to parameter defaults and points both selectors at the almost-empty register. The thresholds leave the block as quasi-static values for the flag comparators.

Top module: `ofs_load_seq`

## Requirements
- R1: After reset, ae_off_o equals AE_DEF, af_off_o equals AF_DEF, rb_data_o is zero and rb_valid_o is low.
- R2: A wclk rising edge with load_ni=0 and wen_ni=0 writes din_i[OW-1:0] into one threshold register. Such edges after reset alternate between them: the 1st writes ae_off_o, the 2nd writes af_off_o, the 3rd writes ae_off_o again, and so on.
- R3: A wclk edge with load_ni=0 and wen_ni=1 changes neither threshold and does not advance the write selector.
- R4: fifo_wr_o is high exactly when load_ni=1 and wen_ni=0. Such writes leave both thresholds unchanged and do not advance the write selector.
- R5: Programming can stop after one register by taking load_ni high. The next load write continues with the register that follows in the order.
- R6: A rclk rising edge with load_ni=0 and ren_ni=0 drives rb_data_o with the zero-extended threshold chosen by the read selector, and drives rb_valid_o high for that cycle. Successive readbacks alternate almost-empty, almost-full, almost-empty and so on.
- R7: fifo_rd_o is high exactly when load_ni=1 and ren_ni=0. Such reads do not advance the read selector.
- R8: On a rclk edge without a readback, rb_valid_o goes low and rb_data_o holds its value. The read selector moves independently of the write selector.
- R9: Only din_i[OW-1:0] is loaded. Bits at and above OW have no effect on the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Threshold access select, active low |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| din_i | input | DW | Write data bus |
| fifo_wr_o | output | 1 | Qualified FIFO write strobe |
| fifo_rd_o | output | 1 | Qualified FIFO read strobe |
| ae_off_o | output | OW | Almost-empty threshold |
| af_off_o | output | OW | Almost-full threshold |
| rb_data_o | output | DW | Threshold readback data |
| rb_valid_o | output | 1 | Readback data updated this cycle |

## Verification
The assertions assume that load_ni stays steady across the write and read edges of a cycle. They also assume that the clock domains read the thresholds only after the writes have settled, so a readback never races a threshold write. The bench changes every input only on the falling edge of wclk. rclk runs at the same rate, 3 ns behind wclk, so each cycle has one write edge and then one read edge. The random part of the bench drives load_ni low about half the time, which mixes programming with ordinary traffic. It also randomizes the upper data bits so that R9 is exercised.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int unsigned NUM_OFS = 2;
  localparam int unsigned SEL_W   = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/ofs_seq_sel.sv
module ofs_seq_sel
  import ofs_pkg::*;
#(
  parameter int unsigned N = NUM_OFS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_o <= SEL_W'(SEL_AE);
    else if (adv_i) sel_o <= (sel_o == LAST) ? '0 : sel_o + 1'b1;
  end
endmodule

// File: rtl/ofs_wr_port.sv
module ofs_wr_port
  import ofs_pkg::*;
#(
  parameter int unsigned DW     = 18,
  parameter int unsigned OW     = 14,
  parameter int unsigned AE_DEF = 127,
  parameter int unsigned AF_DEF = 127
) (
  input  logic                         wclk_i,
  input  logic                         rst_ni,
  input  logic                         load_ni,
  input  logic                         wen_ni,
  input  logic [DW-1:0]                din_i,
  output logic                         fifo_wr_o,
  output logic [NUM_OFS-1:0][OW-1:0]   ofs_o
);
  localparam logic [NUM_OFS-1:0][OW-1:0] DEFS = {OW'(AF_DEF), OW'(AE_DEF)};

  logic             ld_wr;
  logic [SEL_W-1:0] wsel;

  assign ld_wr     = ~load_ni & ~wen_ni;
  assign fifo_wr_o = load_ni & ~wen_ni;

  ofs_seq_sel #(.N(NUM_OFS)) i_wsel (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .adv_i (ld_wr),
    .sel_o (wsel)
  );

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni)                              ofs_o[g] <= DEFS[g];
      else if (ld_wr && wsel == SEL_W'(g))      ofs_o[g] <= din_i[OW-1:0];
    end
  end
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned OW = 14
) (
  input  logic                         rclk_i,
  input  logic                         rst_ni,
  input  logic                         load_ni,
  input  logic                         ren_ni,
  input  logic [NUM_OFS-1:0][OW-1:0]   ofs_i,
  output logic                         fifo_rd_o,
  output logic [DW-1:0]                rb_data_o,
  output logic                         rb_valid_o
);
  logic             ld_rd;
  logic [SEL_W-1:0] rsel;

  assign ld_rd     = ~load_ni & ~ren_ni;
  assign fifo_rd_o = load_ni & ~ren_ni;

  ofs_seq_sel #(.N(NUM_OFS)) i_rsel (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .adv_i (ld_rd),
    .sel_o (rsel)
  );

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_data_o  <= '0;
      rb_valid_o <= 1'b0;
    end else begin
      rb_valid_o <= ld_rd;
      if (ld_rd) rb_data_o <= DW'(ofs_i[rsel]);
    end
  end
endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_pkg::*;
#(
  parameter int unsigned DW     = 18,
  parameter int unsigned OW     = 14,
  parameter int unsigned AE_DEF = 127,
  parameter int unsigned AF_DEF = 127
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          load_ni,
  input  logic          wen_ni,
  input  logic          ren_ni,
  input  logic [DW-1:0] din_i,
  output logic          fifo_wr_o,
  output logic          fifo_rd_o,
  output logic [OW-1:0] ae_off_o,
  output logic [OW-1:0] af_off_o,
  output logic [DW-1:0] rb_data_o,
  output logic          rb_valid_o
);
  logic [NUM_OFS-1:0][OW-1:0] ofs;

  ofs_wr_port #(.DW(DW), .OW(OW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) i_wr (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .load_ni  (load_ni),
    .wen_ni   (wen_ni),
    .din_i    (din_i),
    .fifo_wr_o(fifo_wr_o),
    .ofs_o    (ofs)
  );

  ofs_rd_port #(.DW(DW), .OW(OW)) i_rd (
    .rclk_i    (rclk_i),
    .rst_ni    (rst_ni),
    .load_ni   (load_ni),
    .ren_ni    (ren_ni),
    .ofs_i     (ofs),
    .fifo_rd_o (fifo_rd_o),
    .rb_data_o (rb_data_o),
    .rb_valid_o(rb_valid_o)
  );

  assign ae_off_o = ofs[SEL_AE];
  assign af_off_o = ofs[SEL_AF];
endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk #(
  parameter int unsigned DW = 18,
  parameter int unsigned OW = 14
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          load_ni,
  input logic          wen_ni,
  input logic          ren_ni,
  input logic [DW-1:0] din_i,
  input logic          fifo_wr_o,
  input logic          fifo_rd_o,
  input logic [OW-1:0] ae_off_o,
  input logic [OW-1:0] af_off_o,
  input logic [DW-1:0] rb_data_o,
  input logic          rb_valid_o
);
  assert_one_reg_R2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(!$stable(ae_off_o) && !$stable(af_off_o)));

  assert_noop_hold_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (load_ni || wen_ni) |=> ($stable(ae_off_o) && $stable(af_off_o)));

  assert_wr_gate_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (load_ni && !wen_ni));

  assert_rb_valid_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!load_ni && !ren_ni) |=> rb_valid_o);

  assert_rd_gate_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    fifo_rd_o |-> (load_ni && !ren_ni));

  assert_rb_hold_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (load_ni || ren_ni) |=> (!rb_valid_o && $stable(rb_data_o)));

  assert_low_bits_R9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!load_ni && !wen_ni) |=>
      (ae_off_o == $past(din_i[OW-1:0]) || af_off_o == $past(din_i[OW-1:0])));
endmodule

bind ofs_load_seq ofs_load_seq_chk #(.DW(DW), .OW(OW)) i_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .load_ni   (load_ni),
  .wen_ni    (wen_ni),
  .ren_ni    (ren_ni),
  .din_i     (din_i),
  .fifo_wr_o (fifo_wr_o),
  .fifo_rd_o (fifo_rd_o),
  .ae_off_o  (ae_off_o),
  .af_off_o  (af_off_o),
  .rb_data_o (rb_data_o),
  .rb_valid_o(rb_valid_o)
);

// File: tb/test_ofs_load_seq.sv
module test_ofs_load_seq;
  localparam int unsigned DW = 18;
  localparam int unsigned OW = 14;
  localparam int unsigned AE_DEF = 127;
  localparam int unsigned AF_DEF = 200;

  logic wclk, rclk, rst_n, load_n, wen_n, ren_n;
  logic [DW-1:0] din;
  logic fifo_wr, fifo_rd, rb_valid;
  logic [OW-1:0] ae_off, af_off;
  logic [DW-1:0] rb_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [OW-1:0] m_ae, m_af;
  logic [DW-1:0] m_rb;
  logic m_wsel, m_rsel, m_rv;

  ofs_load_seq #(.DW(DW), .OW(OW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) i_ofs_load_seq (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .load_ni(load_n), .wen_ni(wen_n),
    .ren_ni(ren_n), .din_i(din), .fifo_wr_o(fifo_wr), .fifo_rd_o(fifo_rd),
    .ae_off_o(ae_off), .af_off_o(af_off), .rb_data_o(rb_data), .rb_valid_o(rb_valid)
  );

  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #3; forever #5 rclk = ~rclk; end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] zext(input logic [OW-1:0] v);
    return DW'(v);
  endfunction

  task automatic step(input bit ld, input bit we, input bit re, input logic [DW-1:0] d);
    bit wrote, read;
    @(negedge wclk);
    load_n = ld; wen_n = we; ren_n = re; din = d;
    #1;
    check(fifo_wr == (ld & ~we), "R4", 32'(fifo_wr), 32'(ld & ~we));
    check(fifo_rd == (ld & ~re), "R7", 32'(fifo_rd), 32'(ld & ~re));
    wrote = !ld && !we;
    read  = !ld && !re;
    if (wrote) begin
      if (!m_wsel) m_ae = d[OW-1:0]; else m_af = d[OW-1:0];
      m_wsel = ~m_wsel;
    end
    if (read) begin
      m_rb = zext(m_rsel ? m_af : m_ae);
      m_rsel = ~m_rsel;
    end
    m_rv = read;
    @(posedge rclk); #1;
    if (wrote) begin
      check(ae_off == m_ae, "R2", 32'(ae_off), 32'(m_ae));
      check(af_off == m_af, "R2", 32'(af_off), 32'(m_af));
    end else begin
      check(ae_off == m_ae, "R3", 32'(ae_off), 32'(m_ae));
      check(af_off == m_af, "R3", 32'(af_off), 32'(m_af));
    end
    check(rb_valid == m_rv, "R6", 32'(rb_valid), 32'(m_rv));
    check(rb_data == m_rb, read ? "R6" : "R8", 32'(rb_data), 32'(m_rb));
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 0; load_n = 1; wen_n = 1; ren_n = 1; din = '0;
    m_ae = OW'(AE_DEF); m_af = OW'(AF_DEF); m_rb = '0; m_wsel = 0; m_rsel = 0; m_rv = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    #1;
    check(ae_off == OW'(AE_DEF), "R1", 32'(ae_off), AE_DEF);
    check(af_off == OW'(AF_DEF), "R1", 32'(af_off), AF_DEF);
    check(rb_data == '0, "R1", 32'(rb_data), 0);
    check(rb_valid == 1'b0, "R1", 32'(rb_valid), 0);

    // readback of defaults in ae/af order (R6)
    step(0, 1, 0, '0);
    check(rb_data == zext(OW'(AE_DEF)), "R6", 32'(rb_data), AE_DEF);
    step(0, 1, 0, '0);
    check(rb_data == zext(OW'(AF_DEF)), "R6", 32'(rb_data), AF_DEF);
    // three load writes: ae, af, ae (R2); upper bits ignored (R9)
    step(0, 0, 1, 18'h3_0011);
    check(ae_off == 14'h0011, "R9", 32'(ae_off), 32'h11);
    step(0, 0, 1, 18'h0_0022);
    check(af_off == 14'h0022, "R2", 32'(af_off), 32'h22);
    step(0, 0, 1, 18'h0_0033);
    check(ae_off == 14'h0033 && af_off == 14'h0022, "R2", 32'(ae_off), 32'h33);
    // no-op with load low, write disabled (R3)
    step(0, 1, 1, 18'h0_3FFF);
    // ordinary writes/reads leave thresholds and selectors alone (R4, R7)
    step(1, 0, 0, 18'h0_1234);
    step(1, 0, 0, 18'h0_1235);
    // partial programming: selector points at af, resumes there (R5)
    step(0, 0, 1, 18'h0_0044);
    check(af_off == 14'h0044 && ae_off == 14'h0033, "R5", 32'(af_off), 32'h44);
    step(1, 1, 1, '0);
    step(0, 0, 1, 18'h0_0055);
    check(ae_off == 14'h0055 && af_off == 14'h0044, "R5", 32'(ae_off), 32'h55);
    // read selector independent: next readback is ae (R8)
    step(0, 1, 1, '0);
    check(rb_valid == 1'b0, "R8", 32'(rb_valid), 0);
    step(0, 1, 0, '0);
    check(rb_data == zext(14'h0055), "R8", 32'(rb_data), 32'h55);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      bit ld, we, re;
      ld = ($urandom % 2) == 0;
      we = ($urandom % 3) == 0;
      re = ($urandom % 3) == 0;
      step(ld, we, re, DW'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule